// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits on the synchronous side of a chip and drives an asynchronous 1M x 16 extended-data-out DRAM. A host presents one request at a time, carrying a 20-bit word address, 16 bits of write data, a byte-lane mask and a read/write flag. The controller splits the address into a 10-bit row and a 10-bit column and sends both over the shared address pins. After an access it leaves the row open, so that a later access to the same row needs only a column cycle. Every strobe edge is placed by cycle counters. The controller derives those counts from nanosecond parameters and the clock period, and each division rounds up.

Reads always strobe both lanes. The controller samples read data on the clock edge that ends the CAS-high recovery phase, which is the point where the next CAS fall could occur. Extended-data-out parts keep the data valid until that point. Writes strobe only the lanes that the mask selects. Refresh belongs to an external engine. It asks through `ref_req`. The controller closes any open row, waits out the precharge time, and then holds `ref_gnt` with every strobe high until the request drops.

The state machine has these states:
- `ST_IDLE`: precharged, with no row open.
- `ST_REFRESH`: the grant is held.
- `ST_ACTIVATE`: RAS is low and the row address is on the pins.
- `ST_COL_SETUP`: the column address is on the pins. For a write, write data and WE are also driven here.
- `ST_CAS_LOW`: the lane strobes are low.
- `ST_CAS_HIGH`: CAS recovery. Read capture happens at the end of this state.
- `ST_OPEN`: the row is open and the controller waits for work.
- `ST_HOLD`: the controller waits for the minimum RAS-low time before closing the row.
- `ST_PRECHARGE`: RAS is high.

The transitions are:
- IDLE goes to REFRESH if `ref_req` is high. Otherwise, an accepted request sends it to ACTIVATE.
- REFRESH goes to IDLE when `ref_req` drops.
- ACTIVATE goes to COL_SETUP, which goes to CAS_LOW, which goes to CAS_HIGH, which goes to OPEN. ACTIVATE, CAS_LOW and CAS_HIGH each last their counted number of cycles. COL_SETUP lasts one cycle.
- From OPEN, a refresh request goes to HOLD. An accepted request to the open row goes to COL_SETUP. An accepted request to another row goes to HOLD, with the request kept pending.
- HOLD goes to PRECHARGE once RAS has been low long enough.
- PRECHARGE goes to ACTIVATE if a request is pending. Otherwise it goes to IDLE.

Top module: `edo_page_ctrl`

## Requirements
- R1: The request address is split with row = addr[19:10] and column = addr[9:0]. The row is on `dram_addr` when RAS falls. The column is on `dram_addr` one cycle before any CAS falls and stays there while CAS is low.
- R2: A request to the row that is already open runs as a column cycle with no RAS rise.
- R3: A request to a different row raises RAS and keeps it high for at least ceil(tRP/clock) cycles before the new row is activated.
- R4: RAS stays low for at least max(ceil(tRAS), ceil(tRC) - ceil(tRP)) cycles. The time from one RAS fall to the next is at least tRC.
- R5: `dram_cas_n[0]` strobes dq[7:0] and `dram_cas_n[1]` strobes dq[15:8]. A write pulls low only the lanes whose `req_be` bit is 1. The unselected lane's stored byte is unchanged. A mask of 00 writes nothing. No CAS goes low while RAS is high.
- R6: A read pulls both lanes low. `rsp_valid` is high for exactly one cycle with the word read, and responses come back in request order. Data is sampled at the edge that ends the CAS-high recovery, at least tRAC after the RAS fall and at least tCAC after the CAS fall.
- R7: During a write, the bus is driven and WE is low one cycle before CAS falls. The bus is released, with WE high, in the CAS-high cycle that follows. OE is never low at the same time as WE. OE is low only in the CAS phases of a read.
- R8: While `ref_req` is high, the open row is closed and then `ref_gnt` is held with RAS, both CAS lanes, WE and OE high, and `req_ready` is low. Refresh takes priority over a waiting request. After the grant ends, the next access opens its row afresh.
- R9: After reset, the strobes are high, `dram_dq_oe`, `rsp_valid` and `ref_gnt` are low, and `req_ready` is high when no refresh is requested.
- R10: Reads and writes mixed within one open row all run as page cycles without a RAS rise, and each read returns the latest data written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request is accepted on this edge if valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in [19:10], column in [9:0] |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane mask for writes, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data |
| ref_req | input | 1 | External refresh engine asks for the DRAM |
| ref_gnt | output | 1 | DRAM is precharged and idle for refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Enables the data driver |
| dram_dq_in | input | 16 | Data returned from the DRAM |

## Verification
The assertions check every cycle that:
- RAS stays low for at least the minimum count and stays high for at least the precharge count;
- no lane strobe goes low outside an open row;
- write data and WE lead the CAS fall, and OE and WE are never both low;
- the refresh grant keeps all strobes high and `req_ready` low;
- a response follows an OE-low cycle.

Several behaviours need the bench's DRAM model and scoreboard. These are:
- the address split;
- whether a page hit really avoids reopening the row;
- byte-lane merging and the empty mask;
- data timing against tRAC and tCAC in nanoseconds;
- the reopen after refresh.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REFRESH,
        ST_ACTIVATE,
        ST_COL_SETUP,
        ST_CAS_LOW,
        ST_CAS_HIGH,
        ST_OPEN,
        ST_HOLD,
        ST_PRECHARGE
    } ctl_state_t;

    // Whole clock cycles needed to cover a time in ns, rounded up.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_step_timer.sv
module edo_step_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/edo_row_track.sv
module edo_row_track #(
    parameter int ROW_W = 10,
    parameter int HOLD  = 6,
    parameter int AGE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] open_row_i,
    input  logic [ROW_W-1:0] probe_row_i,
    output logic             hit_o,
    output logic             age_ok_o
);

    logic             is_open;
    logic [ROW_W-1:0] row_q;
    logic [AGE_W-1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
            row_q   <= '0;
            age     <= '0;
        end else if (open_i) begin
            is_open <= 1'b1;
            row_q   <= open_row_i;
            age     <= AGE_W'(1);
        end else if (close_i) begin
            is_open <= 1'b0;
        end else if (is_open && (age != '1)) begin
            age <= age + 1'b1;
        end
    end

    assign hit_o    = is_open && (row_q == probe_row_i);
    assign age_ok_o = is_open && (age >= AGE_W'(HOLD));

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
    import edo_ctrl_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 10,
    parameter int DQ_W      = 16,
    parameter int CLK_NS    = 10,
    parameter int T_RAC_NS  = 50,
    parameter int T_CAC_NS  = 13,
    parameter int T_AA_NS   = 25,
    parameter int T_PC_NS   = 20,
    parameter int T_RC_NS   = 84,
    parameter int T_RAS_NS  = 50,
    parameter int T_RP_NS   = 30,
    parameter int T_CP_NS   = 10,
    parameter int T_OEA_NS  = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_wr,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic [DQ_W-1:0]          req_wdata,
    input  logic [DQ_W/8-1:0]        req_be,
    output logic                     rsp_valid,
    output logic [DQ_W-1:0]          rsp_rdata,
    input  logic                     ref_req,
    output logic                     ref_gnt,
    output logic                     dram_ras_n,
    output logic [DQ_W/8-1:0]        dram_cas_n,
    output logic                     dram_we_n,
    output logic                     dram_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic [DQ_W-1:0]          dram_dq_out,
    output logic                     dram_dq_oe,
    input  logic [DQ_W-1:0]          dram_dq_in
);

    localparam int ADDR_W = ROW_W + COL_W;
    localparam int LANES  = DQ_W / 8;
    localparam int MUX_W  = imax(ROW_W, COL_W);

    localparam int C_RAC = ns_to_cyc(T_RAC_NS, CLK_NS);
    localparam int C_CAC = ns_to_cyc(T_CAC_NS, CLK_NS);
    localparam int C_AA  = ns_to_cyc(T_AA_NS,  CLK_NS);
    localparam int C_PC  = ns_to_cyc(T_PC_NS,  CLK_NS);
    localparam int C_RC  = ns_to_cyc(T_RC_NS,  CLK_NS);
    localparam int C_RAS = ns_to_cyc(T_RAS_NS, CLK_NS);
    localparam int C_RP  = imax(1, ns_to_cyc(T_RP_NS, CLK_NS));
    localparam int C_CP  = imax(1, ns_to_cyc(T_CP_NS, CLK_NS));
    localparam int C_OEA = ns_to_cyc(T_OEA_NS, CLK_NS);

    // Capture is CL+CP cycles after the CAS fall, 1+CL+CP after the column
    // is applied, and a page cycle lasts CL+CP+2 cycles.
    localparam int C_CL  = imax(imax(1, C_CAC - C_CP),
                                imax(imax(C_OEA - C_CP, C_AA - 1 - C_CP),
                                     C_PC - 2 - C_CP));
    localparam int C_RCD = imax(1, C_RAC - 1 - C_CL - C_CP);
    localparam int C_HOLD = imax(C_RAS, C_RC - C_RP);

    localparam int TMR_MAX = imax(imax(C_RCD, C_CL), imax(C_CP, C_RP));
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int AGE_W   = $clog2(C_HOLD + 1) + 1;

    ctl_state_t state, nxt;

    logic              cur_wr,    cur_wr_d;
    logic [ADDR_W-1:0] cur_addr,  cur_addr_d;
    logic [DQ_W-1:0]   cur_wdata, cur_wdata_d;
    logic [LANES-1:0]  cur_be,    cur_be_d;
    logic              pend,      pend_d;

    logic              accept;
    logic              tmr_load, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic              trk_open, trk_close, row_hit, age_ok;

    edo_step_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    edo_row_track #(.ROW_W(ROW_W), .HOLD(C_HOLD), .AGE_W(AGE_W)) u_rows (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_i      (trk_open),
        .close_i     (trk_close),
        .open_row_i  (cur_addr_d[ADDR_W-1:COL_W]),
        .probe_row_i (req_addr[ADDR_W-1:COL_W]),
        .hit_o       (row_hit),
        .age_ok_o    (age_ok)
    );

    assign req_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !ref_req;
    assign accept    = req_ready && req_valid;

    always_comb begin
        nxt       = state;
        pend_d    = pend;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        trk_open  = 1'b0;
        trk_close = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ref_req) begin
                    nxt = ST_REFRESH;
                end else if (req_valid) begin
                    nxt      = ST_ACTIVATE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(C_RCD - 1);
                    trk_open = 1'b1;
                end
            end
            ST_REFRESH: begin
                if (!ref_req) nxt = ST_IDLE;
            end
            ST_ACTIVATE: begin
                if (tmr_done) nxt = ST_COL_SETUP;
            end
            ST_COL_SETUP: begin
                nxt      = ST_CAS_LOW;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(C_CL - 1);
            end
            ST_CAS_LOW: begin
                if (tmr_done) begin
                    nxt      = ST_CAS_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(C_CP - 1);
                end
            end
            ST_CAS_HIGH: begin
                if (tmr_done) nxt = ST_OPEN;
            end
            ST_OPEN: begin
                if (ref_req) begin
                    nxt    = ST_HOLD;
                    pend_d = 1'b0;
                end else if (req_valid) begin
                    if (row_hit) begin
                        nxt = ST_COL_SETUP;
                    end else begin
                        nxt    = ST_HOLD;
                        pend_d = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (age_ok) begin
                    nxt       = ST_PRECHARGE;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(C_RP - 1);
                    trk_close = 1'b1;
                end
            end
            ST_PRECHARGE: begin
                if (tmr_done) begin
                    if (pend) begin
                        nxt      = ST_ACTIVATE;
                        pend_d   = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(C_RCD - 1);
                        trk_open = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        cur_wr_d    = cur_wr;
        cur_addr_d  = cur_addr;
        cur_wdata_d = cur_wdata;
        cur_be_d    = cur_be;
        if (accept) begin
            cur_wr_d    = req_wr;
            cur_addr_d  = req_addr;
            cur_wdata_d = req_wdata;
            cur_be_d    = req_be;
        end
    end

    // State register and the latched request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend      <= 1'b0;
            cur_wr    <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_be    <= '0;
        end else begin
            state     <= nxt;
            pend      <= pend_d;
            cur_wr    <= cur_wr_d;
            cur_addr  <= cur_addr_d;
            cur_wdata <= cur_wdata_d;
            cur_be    <= cur_be_d;
        end
    end

    // Pin values decoded from the next state, so pins move with the state
    logic             ras_active, col_phase, cas_phase, wr_drive, rd_oe;
    logic [LANES-1:0] cas_d;
    logic [MUX_W-1:0] addr_d;

    always_comb begin
        ras_active = (nxt == ST_ACTIVATE) || (nxt == ST_COL_SETUP) ||
                     (nxt == ST_CAS_LOW)  || (nxt == ST_CAS_HIGH)  ||
                     (nxt == ST_OPEN)     || (nxt == ST_HOLD);
        col_phase  = (nxt == ST_COL_SETUP) || (nxt == ST_CAS_LOW) ||
                     (nxt == ST_CAS_HIGH);
        cas_phase  = (nxt == ST_CAS_LOW);
        wr_drive   = cur_wr_d && ((nxt == ST_COL_SETUP) || (nxt == ST_CAS_LOW));
        rd_oe      = !cur_wr_d && ((nxt == ST_CAS_LOW) || (nxt == ST_CAS_HIGH));
        addr_d     = col_phase ? MUX_W'(cur_addr_d[COL_W-1:0])
                               : MUX_W'(cur_addr_d[ADDR_W-1:COL_W]);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign cas_d[g] = !(cas_phase && (!cur_wr_d || cur_be_d[g]));
    end

    logic capture;
    assign capture = (state == ST_CAS_HIGH) && tmr_done && !cur_wr;

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_ras_n  <= 1'b1;
            dram_cas_n  <= '1;
            dram_we_n   <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_addr   <= '0;
            dram_dq_out <= '0;
            dram_dq_oe  <= 1'b0;
            ref_gnt     <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
        end else begin
            dram_ras_n  <= !ras_active;
            dram_cas_n  <= cas_d;
            dram_we_n   <= !wr_drive;
            dram_oe_n   <= !rd_oe;
            dram_addr   <= addr_d;
            dram_dq_out <= cur_wdata_d;
            dram_dq_oe  <= wr_drive;
            ref_gnt     <= (nxt == ST_REFRESH);
            rsp_valid   <= capture;
            if (capture) rsp_rdata <= dram_dq_in;
        end
    end

endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk
    import edo_ctrl_pkg::*;
#(
    parameter int DQ_W     = 16,
    parameter int MUX_W    = 10,
    parameter int ADDR_W   = 20,
    parameter int CLK_NS   = 10,
    parameter int T_RC_NS  = 84,
    parameter int T_RAS_NS = 50,
    parameter int T_RP_NS  = 30
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                req_wr,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [DQ_W-1:0]     req_wdata,
    input logic [DQ_W/8-1:0]   req_be,
    input logic                rsp_valid,
    input logic [DQ_W-1:0]     rsp_rdata,
    input logic                ref_req,
    input logic                ref_gnt,
    input logic                dram_ras_n,
    input logic [DQ_W/8-1:0]   dram_cas_n,
    input logic                dram_we_n,
    input logic                dram_oe_n,
    input logic [MUX_W-1:0]    dram_addr,
    input logic [DQ_W-1:0]     dram_dq_out,
    input logic                dram_dq_oe,
    input logic [DQ_W-1:0]     dram_dq_in
);

    localparam int K_RP   = imax(1, ns_to_cyc(T_RP_NS, CLK_NS));
    localparam int K_HOLD = imax(ns_to_cyc(T_RAS_NS, CLK_NS),
                                 ns_to_cyc(T_RC_NS, CLK_NS) - K_RP);

    logic [7:0] low_len, high_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_len  <= '0;
            high_len <= '1;
        end else if (dram_ras_n) begin
            low_len  <= '0;
            if (high_len != '1) high_len <= high_len + 1'b1;
        end else begin
            high_len <= '0;
            if (low_len != '1) low_len <= low_len + 1'b1;
        end
    end

    // R4
    ras_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (low_len >= 8'(K_HOLD)));

    // R3
    ras_pre_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (high_len >= 8'(K_RP)));

    // R5
    cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cas_n != '1) |-> !dram_ras_n);

    // R7
    wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(dram_cas_n) & ~dram_cas_n) != '0) && !dram_we_n)
            |-> $past(dram_dq_oe && !dram_we_n));

    // R7
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dram_oe_n && !dram_we_n));

    // R8
    gnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (dram_ras_n && (dram_cas_n == '1) && dram_we_n &&
                     dram_oe_n && !req_ready));

    // R6
    rsp_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!dram_oe_n));

endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(
    .DQ_W     (DQ_W),
    .MUX_W    (MUX_W),
    .ADDR_W   (ADDR_W),
    .CLK_NS   (CLK_NS),
    .T_RC_NS  (T_RC_NS),
    .T_RAS_NS (T_RAS_NS),
    .T_RP_NS  (T_RP_NS)
) u_chk (.*);

// File: tb/edo_page_ctrl_tb.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb;

    localparam int T_RAC = 50;
    localparam int T_CAC = 13;
    localparam int T_RC  = 84;
    localparam int T_RAS = 50;
    localparam int T_RP  = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_wr = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid, ref_gnt;
    logic        ref_req = 1'b0;
    logic [15:0] rsp_rdata;
    logic        dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [1:0]  dram_cas_n;
    logic [9:0]  dram_addr;
    logic [15:0] dram_dq_out, dram_dq_in;

    always #5 clk = ~clk;

    edo_page_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // ---------------- DRAM model ----------------
    logic [15:0] mem    [bit [19:0]];
    logic [15:0] shadow [bit [19:0]];
    logic [9:0]  m_row = '0, m_col = '0;
    logic [1:0]  m_lanes = '0;
    int          m_wr_events = 0;
    int          ras_falls = 0;
    longint      ras_fall_t = -1000, ras_rise_t = -1000, cas_fall_t = 0;
    logic [15:0] m_rd = '0;
    logic        m_rd_ok = 1'b0;
    wire         cas_any_n = &dram_cas_n;

    assign dram_dq_in = (!dram_oe_n && m_rd_ok) ? m_rd : 16'hDEAD;

    function automatic logic [15:0] mem_rd(input logic [19:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] sh_rd(input logic [19:0] a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    always begin
        @(negedge dram_ras_n);
        #1;
        check(cas_any_n, "R5 no strobe before row open", 32'(dram_cas_n), 32'h3);
        check(($time - 1 - ras_rise_t) >= T_RP, "R3 precharge width ns",
              32'($time - 1 - ras_rise_t), 32'(T_RP));
        if (ras_falls > 0)
            check(($time - 1 - ras_fall_t) >= T_RC, "R4 RAS fall-to-fall ns",
                  32'($time - 1 - ras_fall_t), 32'(T_RC));
        m_row      = dram_addr;
        ras_fall_t = $time - 1;
        ras_falls++;
    end

    always begin
        @(posedge dram_ras_n);
        m_rd_ok = 1'b0;
        check(($time - ras_fall_t) >= T_RAS, "R4 RAS low width ns",
              32'($time - ras_fall_t), 32'(T_RAS));
        ras_rise_t = $time;
    end

    always begin
        longint vt;
        @(negedge cas_any_n);
        #1;
        cas_fall_t = $time - 1;
        m_col      = dram_addr;
        m_rd_ok    = 1'b0;
        if (!dram_we_n) begin
            check(dram_dq_oe && dram_oe_n, "R7 bus driven, OE high at write strobe",
                  {30'd0, dram_dq_oe, dram_oe_n}, 32'h3);
            m_lanes = ~dram_cas_n;
            m_wr_events++;
            if (!dram_cas_n[0]) mem[{m_row, m_col}][7:0]  = dram_dq_out[7:0];
            if (!dram_cas_n[1]) mem[{m_row, m_col}][15:8] = dram_dq_out[15:8];
        end else begin
            check(dram_cas_n == 2'b00, "R6 read strobes both lanes",
                  32'(dram_cas_n), 32'h0);
            // one ns margin so the data never lands on the sampling edge
            vt = cas_fall_t + T_CAC - 1;
            if (ras_fall_t + T_RAC - 1 > vt) vt = ras_fall_t + T_RAC - 1;
            #(vt - $time);
            m_rd    = mem_rd({m_row, m_col});
            m_rd_ok = !dram_ras_n;
        end
    end

    // ---------------- scoreboard ----------------
    logic [15:0] exp_q[$];

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 response with none expected", 32'(rsp_rdata), 32'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(rsp_rdata == e, "R6 read data in order", 32'(rsp_rdata), 32'(e));
            end
        end
    end

    task automatic drive(input bit wr, input logic [19:0] a,
                         input logic [15:0] d, input logic [1:0] be);
        logic [15:0] cur;
        @(negedge clk);
        if (wr) begin
            cur = sh_rd(a);
            if (be[0]) cur[7:0]  = d[7:0];
            if (be[1]) cur[15:8] = d[15:8];
            shadow[a] = cur;
        end else begin
            exp_q.push_back(sh_rd(a));
        end
        req_wr = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        int rf;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(dram_ras_n && (dram_cas_n == 2'b11) && dram_we_n && dram_oe_n,
              "R9 strobes high after reset",
              {28'd0, dram_ras_n, dram_cas_n[0], dram_we_n, dram_oe_n}, 32'hF);
        check(!dram_dq_oe && !rsp_valid && !ref_gnt, "R9 outputs idle after reset",
              {29'd0, dram_dq_oe, rsp_valid, ref_gnt}, 32'h0);
        check(req_ready, "R9 ready after reset", 32'(req_ready), 32'h1);

        // R1 address split, basic write and read
        drive(1'b1, 20'h12345, 16'hA5C3, 2'b11);
        repeat (6) @(negedge clk);
        check(m_row == 10'h048, "R1 row bits addr[19:10]", 32'(m_row), 32'h48);
        check(m_col == 10'h345, "R1 column bits addr[9:0]", 32'(m_col), 32'h345);
        drive(1'b0, 20'h12345, 16'h0, 2'b00);

        // R2 R10 page hits mixing reads and writes in row 0x048
        rf = ras_falls;
        drive(1'b1, 20'h12000, 16'h1111, 2'b11);
        drive(1'b0, 20'h12345, 16'h0, 2'b00);
        drive(1'b1, 20'h123FF, 16'h2222, 2'b11);
        drive(1'b0, 20'h12000, 16'h0, 2'b00);
        drive(1'b0, 20'h123FF, 16'h0, 2'b00);
        repeat (8) @(negedge clk);
        check(ras_falls == rf, "R2 R10 same-row accesses keep RAS low",
              32'(ras_falls), 32'(rf));

        // R5 byte lanes
        drive(1'b1, 20'h12345, 16'h1177, 2'b01);
        repeat (6) @(negedge clk);
        check(m_lanes == 2'b01, "R5 low-lane write strobes lane 0 only",
              32'(m_lanes), 32'h1);
        drive(1'b1, 20'h12345, 16'h88EE, 2'b10);
        repeat (6) @(negedge clk);
        check(m_lanes == 2'b10, "R5 high-lane write strobes lane 1 only",
              32'(m_lanes), 32'h2);
        rf = m_wr_events;
        drive(1'b1, 20'h12345, 16'hFFFF, 2'b00);
        repeat (6) @(negedge clk);
        check(m_wr_events == rf, "R5 empty mask writes nothing",
              32'(m_wr_events), 32'(rf));
        drive(1'b0, 20'h12345, 16'h0, 2'b00);

        // R3 row miss reopens
        rf = ras_falls;
        drive(1'b1, 20'hC0010, 16'h3C3C, 2'b11);
        repeat (8) @(negedge clk);
        check(ras_falls == rf + 1, "R3 new row opens once", 32'(ras_falls), 32'(rf + 1));
        drive(1'b0, 20'hC0010, 16'h0, 2'b00);
        drive(1'b0, 20'h12000, 16'h0, 2'b00);
        drive(1'b0, 20'h7ABCD, 16'h0, 2'b00);

        // R8 refresh grant while a row is open and a request waits
        repeat (2) @(negedge clk);
        ref_req = 1'b1;
        rf = 0;
        while (!ref_gnt && rf < 50) begin
            @(negedge clk);
            rf++;
        end
        check(ref_gnt, "R8 grant after closing row", 32'(ref_gnt), 32'h1);
        req_wr = 1'b0; req_addr = 20'h7ABCD; req_be = 2'b00; req_valid = 1'b1;
        rf = ras_falls;
        repeat (5) begin
            @(negedge clk);
            check(ref_gnt && !req_ready && dram_ras_n && (dram_cas_n == 2'b11),
                  "R8 grant holds strobes high and blocks requests",
                  {28'd0, ref_gnt, req_ready, dram_ras_n, dram_cas_n[0]}, 32'hB);
        end
        req_valid = 1'b0;
        check(ras_falls == rf, "R8 no row opened during grant", 32'(ras_falls), 32'(rf));
        ref_req = 1'b0;
        @(negedge clk);
        drive(1'b0, 20'h7ABCD, 16'h0, 2'b00);
        repeat (8) @(negedge clk);
        check(ras_falls == rf + 1, "R8 row reopened after grant",
              32'(ras_falls), 32'(rf + 1));

        // R6 mixed traffic over two rows
        for (int i = 0; i < 12; i++)
            drive(1'b1, {((i % 2) == 0) ? 10'h001 : 10'h2F0, 10'(i * 37)},
                  16'(16'h4000 + i * 16'h0123), 2'b11);
        for (int i = 11; i >= 0; i--)
            drive(1'b0, {((i % 2) == 0) ? 10'h001 : 10'h2F0, 10'(i * 37)},
                  16'h0, 2'b00);

        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, "R6 every read answered", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule